// File: doc/BRIEF.md
# Grouped Prescaler and Shift-Divider Tick Generator

This block turns one fast reference clock into five single-cycle count-enable strobes, one per timer channel. Two 8-bit prescalers run side by side: the first paces channels 0 and 1, the second paces channels 2, 3 and 4. Each channel then thins its group's prescaler strobes with its own power-of-two divider, chosen by a 4-bit field. A timer channel counts once for each tick it receives.

Both configuration inputs come straight from a register file and can change in any cycle. A change to a prescaler value reloads that prescaler and restarts the dividers of its group. A change to one divider field restarts only that channel's divider. After either kind of change, the new rate holds from the very next period. After reset the register file supplies a prescaler word of 0x0101 and a divider word of 0.

Top module: `pwm_tick_gen`

## Requirements
- R1: Channels 0 and 1 take their rate from prescaler A (`pre_cfg[7:0]`). With a divider field of 0 they tick once every P+1 cycles, where P is the prescaler value.
- R2: Channels 2, 3 and 4 take their rate from prescaler B (`pre_cfg[15:8]`). With a divider field of 0 they tick once every P+1 cycles, independently of prescaler A.
- R3: Channel c reads its divider field n from `div_cfg[4c+3:4c]`. It ticks once every (P+1)·2^n cycles.
- R4: A divider field above 4 behaves exactly like a field of 4, which gives division by 16.
- R5: When a channel's period is longer than one cycle, each of its ticks is high for exactly one cycle.
- R6: With a prescaler value of 0 and a divider field of 0, the channel's tick stays high in every cycle.
- R7: When a prescaler value changes, every channel of that group restarts. The first new tick is high in the cycle that begins exactly (P+1)·2^n clock edges after the edge that captured the change.
- R8: While reset is asserted, all tick outputs are 0.
- R9: A change to one channel's divider field clears that channel's divider count. Its ticks then follow the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| pre_cfg | input | 16 | Prescaler values: [7:0] for group A, [15:8] for group B |
| div_cfg | input | 20 | Divider fields: 4 bits per channel at [4c+3:4c] |
| tick_o | output | 5 | Single-cycle count-enable strobe per channel |

## Verification
A configuration change is captured on the first rising edge after it is driven. The registered tick for a restarted channel then rises exactly one full period later, so it is first seen at the falling edge numbered period+1 after the change. The bench drives inputs just after a falling edge and samples only on falling edges. It counts those falling edges against that figure for the restart case. Steady-state periods are measured from one observed tick to the next, so the arbitrary phase of a partial first period after a change never enters a comparison.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;
  parameter int TG_NUM_CH    = 5;  // timer channels
  parameter int TG_GRP_A_CH  = 2;  // channels [0, TG_GRP_A_CH) use prescaler A
  parameter int TG_PRE_W     = 8;  // prescaler value width
  parameter int TG_DIV_W     = 4;  // divider field width
  parameter int TG_MAX_SHIFT = 4;  // largest honoured divider exponent
endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler #(
  parameter int PRE_W = tick_gen_pkg::TG_PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] pre_i,
  output logic             strb_o,
  output logic             restart_o
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] pre_q;

  assign restart_o = (pre_i != pre_q);

  always_comb begin
    cnt_d  = cnt_q;
    strb_o = 1'b0;
    if (restart_o) begin
      cnt_d = pre_i;
    end else if (cnt_q == '0) begin
      cnt_d  = pre_q;
      strb_o = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pre_q <= pre_i;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_o |-> cnt_q <= pre_q); // R1
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strb_o |=> cnt_q == $past(pre_q)); // R1
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> cnt_q == $past(pre_i)); // R7
endmodule

// File: rtl/tg_divider.sv
module tg_divider #(
  parameter int DIV_W     = tick_gen_pkg::TG_DIV_W,
  parameter int MAX_SHIFT = tick_gen_pkg::TG_MAX_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strb_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] field_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] MAX_F = DIV_W'(MAX_SHIFT);

  logic [DIV_W-1:0]     field_q;
  logic [DIV_W-1:0]     shift_c;
  logic [MAX_SHIFT-1:0] mask_c;
  logic [MAX_SHIFT-1:0] dcnt_q, dcnt_d;
  logic                 tick_d;
  logic                 chg_c;

  assign chg_c   = restart_i || (field_i != field_q);
  assign shift_c = (field_q > MAX_F) ? MAX_F : field_q;

  always_comb begin
    mask_c = '0;
    for (int i = 0; i < MAX_SHIFT; i++) begin
      mask_c[i] = (i < int'(shift_c));
    end
  end

  always_comb begin
    dcnt_d = dcnt_q;
    tick_d = 1'b0;
    if (chg_c) begin
      dcnt_d = '0;
    end else if (strb_i) begin
      dcnt_d = dcnt_q + 1'b1;
      tick_d = ((dcnt_q & mask_c) == mask_c);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
      dcnt_q  <= '0;
      tick_o  <= 1'b0;
    end else begin
      field_q <= field_i;
      dcnt_q  <= dcnt_d;
      tick_o  <= tick_d;
    end
  end

  AST_TICK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(strb_i)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_i && !chg_c) |=> $stable(dcnt_q)); // R3
  AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    chg_c |=> (dcnt_q == '0) && !tick_o); // R9
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int NUM_CH    = tick_gen_pkg::TG_NUM_CH,
  parameter int GRP_A_CH  = tick_gen_pkg::TG_GRP_A_CH,
  parameter int PRE_W     = tick_gen_pkg::TG_PRE_W,
  parameter int DIV_W     = tick_gen_pkg::TG_DIV_W,
  parameter int MAX_SHIFT = tick_gen_pkg::TG_MAX_SHIFT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2*PRE_W-1:0]      pre_cfg,
  input  logic [NUM_CH*DIV_W-1:0] div_cfg,
  output logic [NUM_CH-1:0]       tick_o
);
  localparam int NUM_GRP = 2;

  logic [1:0]         rsync_q;
  logic               rst_sync_n;
  logic [NUM_GRP-1:0] grp_strb;
  logic [NUM_GRP-1:0] grp_restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
    tg_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .pre_i    (pre_cfg[g*PRE_W +: PRE_W]),
      .strb_o   (grp_strb[g]),
      .restart_o(grp_restart[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP = (c < GRP_A_CH) ? 0 : 1;
    tg_divider #(.DIV_W(DIV_W), .MAX_SHIFT(MAX_SHIFT)) u_div (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .strb_i   (grp_strb[GRP]),
      .restart_i(grp_restart[GRP]),
      .field_i  (div_cfg[c*DIV_W +: DIV_W]),
      .tick_o   (tick_o[c])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> tick_o == '0); // R8
endmodule

// File: tb/pwm_tick_gen_tb_top.sv
module pwm_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pre_cfg;
  logic [19:0] div_cfg;
  logic [4:0]  tick_o;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwm_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .pre_cfg(pre_cfg), .div_cfg(div_cfg), .tick_o(tick_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_div(input int ch, input int v);
    div_cfg[ch*4 +: 4] = 4'(v);
  endtask

  // period from one observed tick to the next one
  task automatic measure(input int ch, input int exp, input string tag);
    int per;
    per = -1;
    @(negedge clk);
    for (int k = 0; k < 4000 && !tick_o[ch]; k++) @(negedge clk);
    for (int k = 1; k < 4000; k++) begin
      @(negedge clk);
      if (tick_o[ch]) begin per = k; break; end
    end
    check(per == exp, tag, per, exp);
  endtask

  // pulses must never be high in two consecutive samples
  task automatic width_check(input int ch, input int span, input string tag);
    int dbl;
    bit prev;
    dbl = 0; prev = 1'b0;
    for (int k = 0; k < span; k++) begin
      @(negedge clk);
      if (prev && tick_o[ch]) dbl++;
      prev = tick_o[ch];
    end
    check(dbl == 0, tag, dbl, 0);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(tick_o == 5'b0, "R8 ticks low in reset", int'(tick_o), 0);
    end
  endtask

  task automatic t_prescale();
    @(negedge clk);
    pre_cfg = {8'd4, 8'd2};
    div_cfg = '0;
    measure(0, 3, "R1 ch0 prescaler A=2");
    measure(1, 3, "R1 ch1 prescaler A=2");
    measure(2, 5, "R2 ch2 prescaler B=4");
    measure(4, 5, "R2 ch4 prescaler B=4");
  endtask

  task automatic t_divide();
    @(negedge clk);
    set_div(0, 2); set_div(2, 1); set_div(4, 3);
    measure(0, 12, "R3 ch0 n=2");
    measure(2, 10, "R3 ch2 n=1");
    measure(4, 40, "R3 ch4 n=3");
    width_check(0, 60, "R5 ch0 single-cycle pulses");
    width_check(2, 60, "R5 ch2 single-cycle pulses");
  endtask

  task automatic t_clamp();
    @(negedge clk);
    set_div(1, 9);
    measure(1, 48, "R4 ch1 n=9 clamps to 16");
  endtask

  task automatic t_every_cycle();
    int highs;
    @(negedge clk);
    pre_cfg[7:0] = 8'd0;
    set_div(0, 0);
    measure(0, 1, "R6 ch0 period 1");
    highs = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (tick_o[0]) highs++;
    end
    check(highs == 16, "R6 ch0 high every cycle", highs, 16);
    measure(1, 16, "R4 ch1 clamp with P=0");
  endtask

  task automatic t_restart();
    int first;
    first = -1;
    @(negedge clk);
    pre_cfg[15:8] = 8'd3;  // ch2 n=1 -> period 8
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (tick_o[2] && first < 0) first = k;
    end
    check(first == 9, "R7 first tick after prescaler change", first, 9);
    measure(2, 8, "R7 ch2 new period");
  endtask

  task automatic t_field_change();
    @(negedge clk);
    set_div(3, 2);
    measure(3, 16, "R9 ch3 field 0->2");
    @(negedge clk);
    set_div(3, 0);
    measure(3, 4, "R9 ch3 field 2->0");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    pre_cfg = 16'h0101;
    div_cfg = '0;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_prescale();
    t_divide();
    t_clamp();
    t_every_cycle();
    t_restart();
    t_field_change();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule